// File: doc/BRIEF.md
# Function-Coded Integer ALU

This block is a purely combinational arithmetic and logic unit for a processor datapath. Two operands of a parameterized width (32 bits by default) enter together with a 3-bit function code. The block returns one result word and a flag that is high whenever that result is zero. A branch-on-equal decision can use the flag after a subtraction. The block holds no state, so the outputs follow the inputs within the same cycle.

The upper bit of the function code selects the complement of the second operand ahead of a shared stage. That stage holds a bitwise AND, a bitwise OR and one adder. The same bit also feeds the adder's carry input. One adder therefore serves both addition and subtraction, and the complemented AND and OR variants cost no extra gates. Set-less-than is taken from the subtraction with the sign corrected for overflow. One code is reserved and returns zero.

Top module: `alu_fcode_top`

## Requirements
- R1: Code 3'b000 gives `op_a & op_b`.
- R2: Code 3'b001 gives `op_a | op_b`.
- R3: Code 3'b010 gives `op_a + op_b`, with the sum taken modulo 2^WIDTH.
- R4: Code 3'b110 gives `op_a - op_b`, with the difference taken modulo 2^WIDTH.
- R5: Code 3'b100 gives `op_a & ~op_b`.
- R6: Code 3'b101 gives `op_a | ~op_b`.
- R7: Code 3'b111 gives 1 when `op_a` is less than `op_b` as two's-complement signed values and 0 otherwise. The 1 sits in bit 0 and all upper bits are zero. The answer stays correct when the subtraction overflows.
- R8: The reserved code 3'b011 gives a result of all zeros for any operands.
- R9: `zero` is 1 exactly when all bits of `result` are 0, for every code.
- R10: The block is combinational. A change on any input appears at `result` and `zero` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| func | input | 3 | Function code. Bit 2 selects the complement of `op_b` and the adder carry-in. |
| result | output | WIDTH | Result of the selected operation |
| zero | output | 1 | High when `result` is all zeros |

## Verification
The block has no internal state, so any fault appears at the ports as soon as the operands and code that reach the faulty path are applied. Nothing waits for a later cycle. A broken complement or carry-in path shows up as wrong values on every code with bit 2 set. A missing overflow correction shows up only on set-less-than with operands of opposite sign whose difference wraps. The bench therefore sweeps every operand pair of a 4-bit instance under all eight codes. It then drives signed-boundary and pseudo-random patterns into the full-width instance.

// File: rtl/alu_fcode_pkg.sv
package alu_fcode_pkg;

    typedef enum logic [2:0] {
        FN_AND  = 3'b000,
        FN_OR   = 3'b001,
        FN_ADD  = 3'b010,
        FN_RSVD = 3'b011,
        FN_ANDN = 3'b100,
        FN_ORN  = 3'b101,
        FN_SUB  = 3'b110,
        FN_SLT  = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_CMP  = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic cout;
        logic ovf;
        logic sign;
    } add_flags_t;

    function automatic logic fn_invert_b(input logic [2:0] f);
        return f[2];
    endfunction

    function automatic alu_sel_e fn_select(input logic [2:0] f);
        return alu_sel_e'(f[1:0]);
    endfunction

    function automatic logic fn_is_reserved(input logic [2:0] f);
        return (f == FN_RSVD);
    endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             invert,
    output logic [WIDTH-1:0] b_out,
    output logic             carry_in
);
    logic [WIDTH-1:0] inv_mask;

    assign inv_mask = {WIDTH{invert}};
    assign b_out    = b_in ^ inv_mask;
    assign carry_in = invert;
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder
    import alu_fcode_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output add_flags_t       flags
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic p, g;
        assign p          = x[i] ^ y[i];
        assign g          = x[i] & y[i];
        assign sum[i]     = p ^ carry[i];
        assign carry[i+1] = g | (p & carry[i]);
    end

    assign flags.cout = carry[WIDTH];
    assign flags.ovf  = carry[WIDTH] ^ carry[MSB];
    assign flags.sign = sum[MSB];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] and_out,
    output logic [WIDTH-1:0] or_out
);
    assign and_out = x & y;
    assign or_out  = x | y;
endmodule

// File: rtl/alu_fcode_top.sv
module alu_fcode_top
    import alu_fcode_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       func,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    localparam int PAD_W = WIDTH - 1;

    logic [WIDTH-1:0] b_cond;
    logic             cin;
    logic [WIDTH-1:0] sum;
    add_flags_t       flags;
    logic [WIDTH-1:0] and_out, or_out;
    logic             less;
    alu_sel_e         sel;

    alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_in     (op_b),
        .invert   (fn_invert_b(func)),
        .b_out    (b_cond),
        .carry_in (cin)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .x       (op_a),
        .y       (b_cond),
        .and_out (and_out),
        .or_out  (or_out)
    );

    alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x     (op_a),
        .y     (b_cond),
        .cin   (cin),
        .sum   (sum),
        .flags (flags)
    );

    assign less = flags.sign ^ flags.ovf;
    assign sel  = fn_select(func);

    always_comb begin
        unique case (sel)
            SEL_AND: result = and_out;
            SEL_OR:  result = or_out;
            SEL_SUM: result = sum;
            SEL_CMP: result = fn_is_reserved(func) ? '0 : {{PAD_W{1'b0}}, less};
            default: result = '0;
        endcase
    end

    assign zero = ~|result;

    always_comb begin
        if (func == FN_AND)
            a_r1_and_subset: assert ((result & ~op_a) == '0)
                else $error("R1 and result has bits outside op_a");
        if (func == FN_SUB && op_a == op_b)
            a_r4_equal_no_borrow: assert (zero && flags.cout)
                else $error("R4 equal subtract not zero or borrowed");
        if (func == FN_SLT)
            a_r7_slt_boolean: assert (result[WIDTH-1:1] == '0)
                else $error("R7 slt result upper bits set");
        if (func == FN_RSVD)
            a_r8_reserved_zero: assert (zero)
                else $error("R8 reserved code produced nonzero");
        if (func == FN_ORN)
            a_r6_orn_covers_a: assert ((op_a & ~result) == '0)
                else $error("R6 orn result misses op_a bits");
    end
endmodule

// File: tb/tb_alu_fcode_top.sv
module tb_alu_fcode_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int WS = 4;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0]  a, b, r;
    logic [2:0]    f;
    logic          z;
    logic [WS-1:0] as, bs, rs;
    logic [2:0]    fs;
    logic          zs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    alu_fcode_top #(.WIDTH(W)) dut (
        .op_a(a), .op_b(b), .func(f), .result(r), .zero(z)
    );

    alu_fcode_top #(.WIDTH(WS)) dut_small (
        .op_a(as), .op_b(bs), .func(fs), .result(rs), .zero(zs)
    );

    function automatic string tag(input logic [2:0] fc);
        case (fc)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b110: return "R4";
            3'b100: return "R5";
            3'b101: return "R6";
            3'b111: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [W-1:0] model32(input logic [W-1:0] x, y, input logic [2:0] fc);
        case (fc)
            3'b000: return x & y;
            3'b001: return x | y;
            3'b010: return x + y;
            3'b110: return x - y;
            3'b100: return x & ~y;
            3'b101: return x | ~y;
            3'b111: return ($signed(x) < $signed(y)) ? 1 : 0;
            default: return '0;
        endcase
    endfunction

    function automatic logic [WS-1:0] model4(input logic [WS-1:0] x, y, input logic [2:0] fc);
        case (fc)
            3'b000: return x & y;
            3'b001: return x | y;
            3'b010: return x + y;
            3'b110: return x - y;
            3'b100: return x & ~y;
            3'b101: return x | ~y;
            3'b111: return ($signed(x) < $signed(y)) ? 1 : 0;
            default: return '0;
        endcase
    endfunction

    task automatic apply32(input logic [W-1:0] x, y, input logic [2:0] fc);
        logic [W-1:0] exp;
        @(negedge clk);
        a = x; b = y; f = fc;
        #1;
        exp = model32(x, y, fc);
        checks++;
        if (r !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h f=%b result=%h expected=%h", tag(fc), x, y, fc, r, exp);
        end
        checks++;
        if (z !== (exp == '0)) begin
            errors++;
            $display("FAIL R9 a=%h b=%h f=%b zero=%b expected=%b", x, y, fc, z, exp == '0);
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lfsr;
        logic [W-1:0] edge_v [8];
        a = '0; b = '0; f = 3'b000; as = '0; bs = '0; fs = 3'b000;
        repeat (2) @(posedge clk);

        // Exhaustive sweep of the 4-bit instance, R1 to R9
        for (int fc = 0; fc < 8; fc++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++) begin
                    logic [WS-1:0] exp4;
                    @(negedge clk);
                    as = WS'(x); bs = WS'(y); fs = 3'(fc);
                    #1;
                    exp4 = model4(as, bs, fs);
                    checks++;
                    if (rs !== exp4) begin
                        errors++;
                        $display("FAIL %s small a=%h b=%h result=%h expected=%h", tag(fs), as, bs, rs, exp4);
                    end
                    checks++;
                    if (zs !== (exp4 == '0)) begin
                        errors++;
                        $display("FAIL R9 small a=%h b=%h f=%b zero=%b expected=%b", as, bs, fs, zs, exp4 == '0);
                    end
                end

        // Signed boundaries: R7 overflow cases, R3/R4 wrap
        edge_v[0] = 32'h0000_0000; edge_v[1] = 32'h0000_0001;
        edge_v[2] = 32'h7FFF_FFFF; edge_v[3] = 32'h8000_0000;
        edge_v[4] = 32'hFFFF_FFFF; edge_v[5] = 32'h8000_0001;
        edge_v[6] = 32'h5555_5555; edge_v[7] = 32'hAAAA_AAAA;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int fc = 0; fc < 8; fc++)
                    apply32(edge_v[i], edge_v[j], 3'(fc));

        // Pseudo-random patterns across all codes
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] x, y;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            x = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            y = (k % 5 == 0) ? x : lfsr;
            for (int fc = 0; fc < 8; fc++) apply32(x, y, 3'(fc));
        end

        // R10: mid-cycle operand change, no clock edge between
        @(posedge clk);
        #2;
        a = 32'd7; b = 32'd7; f = 3'b110;
        #1;
        checks++;
        if (z !== 1'b1 || r !== '0) begin
            errors++;
            $display("FAIL R10 result=%h zero=%b expected=0 1", r, z);
        end
        b = 32'd3;
        #1;
        checks++;
        if (r !== 32'd4 || z !== 1'b0) begin
            errors++;
            $display("FAIL R10 result=%h zero=%b expected=4 0", r, z);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule